// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block turns single-word read and write requests into the command stream of a four-bank synchronous DRAM with a 16-bit data bus. After reset it brings the memory up. It waits with no-operation commands, closes every bank, gives two refresh cycles and then programs the mode word. From then on it serves one request at a time. Each request opens the row, issues the column access and closes the bank again, either by the auto-precharge bit on the column command or by an explicit precharge.

An interval timer spreads refresh evenly over the rows. The default interval is 64 ms divided by 4096 rows, converted to clock cycles. A refresh that falls due is issued once the access in flight has finished, and it goes ahead of any waiting request. A sideband level puts the memory into self refresh by dropping clock enable and brings it back out again.

Read data is captured 2 or 3 cycles after the read command. The mode word programs this latency, and it is chosen at power-up by a configuration pin. The precharge style is chosen per request.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset, clock enable is high, ready is low, and only NOP is issued for exactly INIT_CYC cycles. Cycle 0 is the first clock after reset is released, so the first other command lands in cycle INIT_CYC.
- R2: Bring-up order is precharge with addr[10]=1 (all banks), refresh, refresh, then mode load. The mode word has addr[2:0]=0 (one-word bursts), addr[3]=0 (sequential) and addr[6:4]=3 when cfg_cas3 is high or 2 when it is low. All other address bits are 0. Ready rises only after all of this.
- R3: The command is {cs_n,ras_n,cas_n,we_n}, with the following codes: mode load=0000, refresh=0001, precharge=0010, activate=0011, write=0100, read=0101, NOP=0111. For an access, activate carries the row on addr. The column command carries the column on addr[COL_W-1:0]. Both carry the request's bank on ba.
- R4: Minimum gaps, counted in cycles from one command to the next, are as follows. Activate to read or write on the same bank: T_RCD. Precharge to any activate or refresh: T_RP. Refresh to any command: T_RFC. Mode load to any command: T_MRD. Write to precharge of that bank: T_WR.
- R5: In the write command cycle, dq_out carries the write data and dq_oe is high. dqm is the inverse of the byte enables: bit 0 is the low byte and bit 1 is the high byte. A masked byte keeps its old content in memory. dq_oe is low in every other cycle.
- R6: Read data on dq_in is sampled in the cycle that is CAS-latency cycles after the read command. It appears on rd_data one cycle later, which is the cycle where done is high.
- R7: addr[10] on the column command equals the req_autopre sampled with the request. When it is 0, a precharge with addr[10]=0 to the same bank follows before ready returns. Whenever ready is high, no bank is open.
- R8: done is a single-cycle pulse. It comes in the cycle after a write command, and CAS latency plus one cycles after a read command.
- R9: A refresh is issued at least once every REFI_CYC cycles plus the length of one access. This holds even when requests are offered back to back.
- R10: Holding selfref_req high while idle issues a refresh with clock enable dropping in the same cycle. Clock enable then stays low with only NOP on the pins until selfref_req falls. After clock enable rises, no command is issued for T_RFC cycles.
- R11: ready is high only when idle with no refresh due and no self-refresh request. A request is taken on a clock edge where req_valid and ready are both high, and ready is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas3 | input | 1 | 1 selects CAS latency 3, 0 selects 2; taken at mode load |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_autopre | input | 1 | 1 close the row with the column command |
| req_bank | input | 2 | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit 0 low byte |
| req_ready | output | 1 | Request can be taken |
| done | output | 1 | Last data beat of the request finished |
| rd_data | output | DATA_W | Captured read data |
| selfref_req | input | 1 | Level request for self refresh |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dqm | output | DATA_W/8 | Data mask, bit 0 low byte |
| sd_dq_out | output | DATA_W | Write data to memory |
| sd_dq_oe | output | 1 | Drive enable for the data bus |
| sd_dq_in | input | DATA_W | Read data from memory |

## Verification
The assertions check the local pin rules on every cycle. Clock enable may fall only with a refresh. While clock enable is low, only NOP or refresh appears. The data bus is driven only with a write. done is never wider than one cycle. ready never coexists with a command on the pins, and it drops right after a request is taken.

Other behaviours span many cycles and can only be shown by the bench scenarios. These are the bring-up order and the mode word for both latencies, and the minimum gaps between commands. They also include the byte-masked merge seen through a later read, and the capture moment under each latency. The last two are refresh keeping its pace under a back-to-back request stream and data surviving a self-refresh period.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_NOP  = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_WAIT,
        ST_BOOT_PRE,
        ST_BOOT_REF1,
        ST_BOOT_REF2,
        ST_BOOT_MODE,
        ST_IDLE,
        ST_OPEN,
        ST_ACCESS,
        ST_CLOSE,
        ST_REFRESH,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_EXIT
    } ctl_state_e;

    localparam int AP_BIT  = 10;  // auto-precharge / all-banks address bit
    localparam int CL_LSB  = 4;   // latency field of the mode word
    localparam int MAX_CL  = 3;

    function automatic logic [2:0] cl_code(input logic cas3);
        return cas3 ? 3'd3 : 3'd2;
    endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int REFI_CYC = 1953
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(REFI_CYC + 1);

    logic [CW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tick <= '0;
            due  <= 1'b0;
        end else if (tick == CW'(REFI_CYC - 1)) begin
            tick <= '0;
            due  <= 1'b1;
        end else begin
            tick <= tick + 1'b1;
            if (ack) due <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_beat_track.sv
module sdram_beat_track
    import sdram_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_fire,
    input  logic              wr_fire,
    input  logic              cas3,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              beat_done
);
    logic [MAX_CL-1:0] rd_pipe;
    logic              capture;

    assign capture = cas3 ? rd_pipe[MAX_CL-1] : rd_pipe[MAX_CL-2];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pipe   <= '0;
            rd_data   <= '0;
            beat_done <= 1'b0;
        end else begin
            rd_pipe   <= {rd_pipe[MAX_CL-2:0], rd_fire};
            beat_done <= capture | wr_fire;
            if (capture) rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int COL_W    = 8,
    parameter int DATA_W   = 16,
    parameter int CLK_NS   = 8,
    parameter int INIT_US  = 100,
    parameter int REF_ROWS = 4096,
    parameter int REF_MS   = 64,
    parameter int INIT_CYC = INIT_US * 1000 / CLK_NS,
    parameter int REFI_CYC = REF_MS * 1000000 / REF_ROWS / CLK_NS,
    parameter int T_RCD    = 3,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 9,
    parameter int T_MRD    = 2,
    parameter int T_WR     = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_cas3,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_autopre,
    input  logic [1:0]            req_bank,
    input  logic [ROW_W-1:0]      req_row,
    input  logic [COL_W-1:0]      req_col,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  req_ready,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  selfref_req,
    output logic                  sd_cke,
    output logic                  sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n,
    output logic [1:0]            sd_ba,
    output logic [ROW_W-1:0]      sd_addr,
    output logic [DATA_W/8-1:0]   sd_dqm,
    output logic [DATA_W-1:0]     sd_dq_out,
    output logic                  sd_dq_oe,
    input  logic [DATA_W-1:0]     sd_dq_in
);
    localparam int MASK_W = DATA_W / 8;
    localparam int CNT_W  = $clog2(INIT_CYC + T_RFC + T_WR + T_RP + T_RCD + T_MRD + MAX_CL + 2);

    typedef struct packed {
        logic              write;
        logic              autopre;
        logic [1:0]        bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [MASK_W-1:0] be;
    } access_t;

    ctl_state_e        state, resume;
    logic [CNT_W-1:0]  wait_cnt;
    access_t           cur;
    logic              cas3_q, booted;

    sd_cmd_e           cmd;
    logic              cke_c, issue, ref_ack, ref_due, sr_active;
    logic [1:0]        ba_c;
    logic [ROW_W-1:0]  addr_c;
    logic [CNT_W-1:0]  gap;
    ctl_state_e        after;
    logic [CNT_W-1:0]  cl_cyc;

    assign cl_cyc = cas3_q ? CNT_W'(3) : CNT_W'(2);

    always_comb begin
        cmd     = CMD_NOP;
        cke_c   = 1'b1;
        ba_c    = '0;
        addr_c  = '0;
        issue   = 1'b0;
        ref_ack = 1'b0;
        gap     = CNT_W'(1);
        after   = ST_IDLE;
        unique case (state)
            ST_BOOT_PRE: begin
                cmd = CMD_PRE; addr_c[AP_BIT] = 1'b1;
                issue = 1'b1; gap = CNT_W'(T_RP); after = ST_BOOT_REF1;
            end
            ST_BOOT_REF1: begin
                cmd = CMD_REF; issue = 1'b1; gap = CNT_W'(T_RFC); after = ST_BOOT_REF2;
            end
            ST_BOOT_REF2: begin
                cmd = CMD_REF; issue = 1'b1; gap = CNT_W'(T_RFC); after = ST_BOOT_MODE;
            end
            ST_BOOT_MODE: begin
                cmd = CMD_MODE; addr_c[CL_LSB +: 3] = cl_code(cfg_cas3);
                issue = 1'b1; gap = CNT_W'(T_MRD); after = ST_IDLE;
            end
            ST_REFRESH: begin
                cmd = CMD_REF; ref_ack = 1'b1;
                issue = 1'b1; gap = CNT_W'(T_RFC); after = ST_IDLE;
            end
            ST_OPEN: begin
                cmd = CMD_ACT; ba_c = cur.bank; addr_c = cur.row;
                issue = 1'b1; gap = CNT_W'(T_RCD); after = ST_ACCESS;
            end
            ST_ACCESS: begin
                cmd = cur.write ? CMD_WR : CMD_RD;
                ba_c = cur.bank;
                addr_c[COL_W-1:0] = cur.col;
                addr_c[AP_BIT] = cur.autopre;
                issue = 1'b1;
                after = cur.autopre ? ST_IDLE : ST_CLOSE;
                if (cur.write) gap = cur.autopre ? CNT_W'(T_WR + T_RP) : CNT_W'(T_WR);
                else           gap = cur.autopre ? cl_cyc + CNT_W'(T_RP) : cl_cyc;
            end
            ST_CLOSE: begin
                cmd = CMD_PRE; ba_c = cur.bank;
                issue = 1'b1; gap = CNT_W'(T_RP); after = ST_IDLE;
            end
            ST_SR_ENTER: begin
                cmd = CMD_REF; cke_c = 1'b0;
                issue = 1'b1; after = ST_SR_HOLD;
            end
            ST_SR_HOLD: cke_c = 1'b0;
            ST_SR_EXIT: begin
                issue = 1'b1; gap = CNT_W'(T_RFC); after = ST_IDLE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_WAIT;
            resume   <= ST_BOOT_PRE;
            wait_cnt <= CNT_W'(INIT_CYC);
            cur      <= '0;
            cas3_q   <= 1'b0;
            booted   <= 1'b0;
        end else begin
            if (state == ST_BOOT_MODE) begin
                cas3_q <= cfg_cas3;
                booted <= 1'b1;
            end
            if (issue) begin
                if (gap <= CNT_W'(1)) begin
                    state <= after;
                end else begin
                    state    <= ST_WAIT;
                    resume   <= after;
                    wait_cnt <= gap - 1'b1;
                end
            end else begin
                unique case (state)
                    ST_WAIT: begin
                        wait_cnt <= wait_cnt - 1'b1;
                        if (wait_cnt <= CNT_W'(1)) state <= resume;
                    end
                    ST_IDLE: begin
                        if (ref_due)          state <= ST_REFRESH;
                        else if (selfref_req) state <= ST_SR_ENTER;
                        else if (req_valid) begin
                            cur   <= '{req_write, req_autopre, req_bank, req_row,
                                       req_col, req_wdata, req_be};
                            state <= ST_OPEN;
                        end
                    end
                    ST_SR_HOLD: if (!selfref_req) state <= ST_SR_EXIT;
                    default: ;
                endcase
            end
        end
    end

    assign sr_active = (state == ST_SR_ENTER) || (state == ST_SR_HOLD) || (state == ST_SR_EXIT);

    sdram_refresh_timer #(.REFI_CYC(REFI_CYC)) refresh_i (
        .clk (clk),
        .rst (rst),
        .en  (booted && !sr_active),
        .ack (ref_ack),
        .due (ref_due)
    );

    sdram_beat_track #(.DATA_W(DATA_W)) beat_i (
        .clk       (clk),
        .rst       (rst),
        .rd_fire   (state == ST_ACCESS && !cur.write),
        .wr_fire   (state == ST_ACCESS && cur.write),
        .cas3      (cas3_q),
        .dq_in     (sd_dq_in),
        .rd_data   (rd_data),
        .beat_done (done)
    );

    assign req_ready = (state == ST_IDLE) && !ref_due && !selfref_req;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke    = cke_c;
    assign sd_ba     = ba_c;
    assign sd_addr   = addr_c;
    assign sd_dq_oe  = (state == ST_ACCESS) && cur.write;
    assign sd_dq_out = cur.wdata;
    assign sd_dqm    = sd_dq_oe ? ~cur.be : '0;
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk (
    input logic clk,
    input logic rst,
    input logic sd_cke,
    input logic sd_cs_n,
    input logic sd_ras_n,
    input logic sd_cas_n,
    input logic sd_we_n,
    input logic sd_dq_oe,
    input logic req_ready,
    input logic req_valid,
    input logic done
);
    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // R10
    cke_low_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> (cmd == 4'b0111 || cmd == 4'b0001));

    // R10
    cke_fall_ref_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sd_cke) |-> cmd == 4'b0001);

    // R5
    oe_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> cmd == 4'b0100);

    // R5
    write_drives_chk: assert property (@(posedge clk) disable iff (rst)
        cmd == 4'b0100 |-> sd_dq_oe);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sd_cke && cmd == 4'b0111));

    // R11
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |=> !req_ready);

    // R4
    ref_then_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (sd_cke && cmd == 4'b0001) |=> cmd == 4'b0111);
endmodule

bind sdram_seq_ctrl sdram_seq_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_dq_oe  (sd_dq_oe),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .done      (done)
);

// File: tb/sdram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdram_seq_ctrl_tb_top;
    localparam int ROW_W = 12, COL_W = 8, DATA_W = 16;
    localparam int INIT_CYC = 20, REFI_CYC = 150;
    localparam int T_RCD = 3, T_RP = 3, T_RFC = 9, T_MRD = 2, T_WR = 2;
    localparam int SLACK = 30;
    localparam logic [3:0] C_MODE = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                           C_NOP = 4'b0111;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_cas3 = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic selfref_req = 1'b0;
    logic req_ready, done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [DATA_W-1:0] rd_data, sd_dq_out;
    logic [DATA_W-1:0] sd_dq_in = 16'hDEAD;
    logic [1:0] sd_ba, sd_dqm;
    logic [ROW_W-1:0] sd_addr;

    always #4 clk = ~clk;

    sdram_seq_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .INIT_CYC(INIT_CYC), .REFI_CYC(REFI_CYC),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_WR(T_WR)
    ) dut_i (
        .clk(clk), .rst(rst), .cfg_cas3(cfg_cas3),
        .req_valid(req_valid), .req_write(req_write), .req_autopre(req_autopre),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .selfref_req(selfref_req),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory and protocol model ----------------
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] mem [int];
    int  rel_cyc, step, cl;
    int  last_pre, last_ref, last_mode, ref_base, rd_due, exp_done;
    int  act_t [4];
    int  wr_t  [4];
    bit  open_b [4];
    bit  exp_is_rd, prev_ready, prev_cke;
    logic [15:0] rd_val, exp_rd;
    logic cur_w, cur_ap;
    logic [1:0] cur_bank, cur_be;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic [15:0] cur_wd;

    function automatic int key(input logic [1:0] b, input logic [ROW_W-1:0] r,
                               input logic [COL_W-1:0] c);
        return int'({b, r, c});
    endfunction

    function automatic bit any_open();
        return open_b[0] | open_b[1] | open_b[2] | open_b[3];
    endfunction

    task automatic model_reset();
        step = 0; last_pre = -1000; last_ref = -1000; last_mode = -1000;
        ref_base = -1000; rd_due = -1; exp_done = -1; exp_is_rd = 0;
        prev_ready = 0; prev_cke = 1;
        for (int i = 0; i < 4; i++) begin act_t[i] = -1000; wr_t[i] = -1000; open_b[i] = 0; end
    endtask

    task automatic timing_common(input int c);
        chk(c - last_pre >= T_RP, "R4 gap after precharge", c - last_pre, T_RP);
        chk(c - last_ref >= T_RFC, "R4 gap after refresh", c - last_ref, T_RFC);
        chk(c - last_mode >= T_MRD, "R4 gap after mode load", c - last_mode, T_MRD);
    endtask

    always @(negedge clk) begin
        logic [3:0] cmd;
        int c;
        c = cyc;
        cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (rst) begin
            model_reset();
            rel_cyc = c + 1;
        end else begin
            sd_dq_in = (c == rd_due) ? rd_val : 16'hDEAD;
            // done / read data timing (R6, R8)
            if (done || c == exp_done) begin
                chk(done && c == exp_done, "R8 done pulse timing", {31'b0, done}, 1);
                if (exp_is_rd && c == exp_done)
                    chk(rd_data == exp_rd, "R6 captured read data", rd_data, exp_rd);
            end
            // accepted request (R11)
            if (req_ready && req_valid) begin
                cur_w = req_write; cur_ap = req_autopre; cur_bank = req_bank;
                cur_row = req_row; cur_col = req_col; cur_wd = req_wdata; cur_be = req_be;
            end
            // bring-up order (R1, R2)
            if (step < 4 && cmd != C_NOP) begin
                case (step)
                    0: begin
                        chk(c == rel_cyc + INIT_CYC, "R1 first command cycle", c - rel_cyc, INIT_CYC);
                        chk(cmd == C_PRE && sd_addr[10], "R2 bring-up precharge all", cmd, C_PRE);
                    end
                    1, 2: chk(cmd == C_REF, "R2 bring-up refresh", cmd, C_REF);
                    default: chk(cmd == C_MODE && sd_addr == {5'b0, (cl == 3) ? 3'd3 : 3'd2, 4'b0},
                                 "R2 mode word", sd_addr, {5'b0, (cl == 3) ? 3'd3 : 3'd2, 4'b0});
                endcase
                step++;
            end
            if (step < 4)
                chk(!req_ready && sd_cke, "R1 quiet during bring-up", req_ready, 0);
            // self refresh (R10)
            if (!sd_cke && cmd != C_REF)
                chk(cmd == C_NOP, "R10 only NOP with clock enable low", cmd, C_NOP);
            if (sd_cke && !prev_cke) begin
                last_ref = c; ref_base = c;
            end
            // commands
            if (sd_cke) begin
                case (cmd)
                    C_ACT: begin
                        timing_common(c);
                        chk(!open_b[sd_ba], "R7 bank closed before activate", open_b[sd_ba], 0);
                        chk(sd_ba == cur_bank && sd_addr == cur_row, "R3 activate bank and row",
                            {sd_ba, sd_addr}, {cur_bank, cur_row});
                        open_b[sd_ba] = 1; act_t[sd_ba] = c;
                    end
                    C_REF: begin
                        timing_common(c);
                        chk(!any_open(), "R4 refresh with banks closed", any_open(), 0);
                        if (step > 4)
                            chk(c - ref_base <= REFI_CYC + SLACK, "R9 refresh pace", c - ref_base, REFI_CYC + SLACK);
                        last_ref = c; ref_base = c;
                    end
                    C_MODE: begin
                        chk(c - last_ref >= T_RFC, "R4 refresh to mode load", c - last_ref, T_RFC);
                        last_mode = c; ref_base = c; step = 5;
                    end
                    C_PRE: begin
                        if (step > 4) begin
                            chk(!sd_addr[10] && sd_ba == cur_bank && !cur_ap,
                                "R7 explicit precharge of the bank", {sd_addr[10], sd_ba}, {1'b0, cur_bank});
                            chk(c - wr_t[sd_ba] >= T_WR, "R4 write to precharge", c - wr_t[sd_ba], T_WR);
                        end
                        if (sd_addr[10]) for (int i = 0; i < 4; i++) open_b[i] = 0;
                        else open_b[sd_ba] = 0;
                        last_pre = c;
                    end
                    C_WR, C_RD: begin
                        chk(open_b[sd_ba] && c - act_t[sd_ba] >= T_RCD, "R4 activate to column",
                            c - act_t[sd_ba], T_RCD);
                        chk(sd_ba == cur_bank && sd_addr[COL_W-1:0] == cur_col, "R3 column address",
                            {sd_ba, sd_addr[COL_W-1:0]}, {cur_bank, cur_col});
                        chk(sd_addr[10] == cur_ap, "R7 auto-precharge bit", sd_addr[10], cur_ap);
                        if (cmd == C_WR) begin
                            logic [15:0] old;
                            chk(sd_dq_oe && sd_dq_out == cur_wd && sd_dqm == ~cur_be,
                                "R5 write bus", {sd_dq_oe, sd_dqm, sd_dq_out}, {1'b1, ~cur_be, cur_wd});
                            old = mem.exists(key(sd_ba, cur_row, cur_col)) ? mem[key(sd_ba, cur_row, cur_col)] : 16'h0;
                            if (!sd_dqm[0]) old[7:0]  = sd_dq_out[7:0];
                            if (!sd_dqm[1]) old[15:8] = sd_dq_out[15:8];
                            mem[key(sd_ba, cur_row, cur_col)] = old;
                            wr_t[sd_ba] = c; exp_done = c + 1; exp_is_rd = 0;
                            if (sd_addr[10]) begin open_b[sd_ba] = 0; last_pre = c + T_WR; end
                        end else begin
                            rd_val = mem.exists(key(sd_ba, cur_row, cur_col)) ? mem[key(sd_ba, cur_row, cur_col)] : 16'h0;
                            rd_due = c + cl; exp_done = c + cl + 1; exp_is_rd = 1; exp_rd = rd_val;
                            if (sd_addr[10]) begin open_b[sd_ba] = 0; last_pre = c + 1; end
                        end
                    end
                    default: ;
                endcase
                if (cmd != C_WR)
                    chk(!sd_dq_oe, "R5 bus released outside writes", sd_dq_oe, 0);
            end
            if (req_ready && !prev_ready)
                chk(!any_open() && step > 4, "R7 all banks closed when ready", any_open(), 0);
            prev_ready = req_ready;
            prev_cke = sd_cke;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_req(input bit w, input bit ap, input logic [1:0] b,
                          input logic [ROW_W-1:0] r, input logic [COL_W-1:0] col,
                          input logic [15:0] wd, input logic [1:0] be, output logic [15:0] rdv);
        req_write = w; req_autopre = ap; req_bank = b; req_row = r; req_col = col;
        req_wdata = wd; req_be = be; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11 ready drops after accept", req_ready, 0);
        while (!done) @(negedge clk);
        rdv = rd_data;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic wr(input bit ap, input logic [1:0] b, input logic [ROW_W-1:0] r,
                      input logic [COL_W-1:0] col, input logic [15:0] wd, input logic [1:0] be);
        logic [15:0] dummy;
        do_req(1'b1, ap, b, r, col, wd, be, dummy);
    endtask

    task automatic rd(input bit ap, input logic [1:0] b, input logic [ROW_W-1:0] r,
                      input logic [COL_W-1:0] col, input logic [15:0] exp, input string tag);
        logic [15:0] v;
        do_req(1'b0, ap, b, r, col, 16'h0, 2'b00, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic phase(input bit cas3);
        int t0;
        rst = 1'b1; cfg_cas3 = cas3; cl = cas3 ? 3 : 2;
        mem.delete();
        repeat (3) @(negedge clk);
        chk(sd_cke && !req_ready && !done, "R1 reset state", {sd_cke, req_ready}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        chk(step == 5, "R2 bring-up complete before ready", step, 5);
        // explicit precharge, byte masking (R5, R7)
        wr(1'b0, 2'd1, 12'd5, 8'd3, 16'hA5A5, 2'b11);
        wr(1'b0, 2'd1, 12'd5, 8'd3, 16'h1234, 2'b01);
        rd(1'b0, 2'd1, 12'd5, 8'd3, 16'hA534, "R5 low-byte merge");
        wr(1'b0, 2'd2, 12'd9, 8'd200, 16'hBEEF, 2'b10);
        rd(1'b0, 2'd2, 12'd9, 8'd200, 16'hBE00, "R5 high-byte only");
        // auto precharge (R7)
        wr(1'b1, 2'd3, 12'd100, 8'd7, 16'h0F0F, 2'b11);
        rd(1'b1, 2'd3, 12'd100, 8'd7, 16'h0F0F, "R7 auto-precharge read");
        wr(1'b1, 2'd3, 12'd101, 8'd7, 16'h5555, 2'b11);
        rd(1'b1, 2'd3, 12'd101, 8'd7, 16'h5555, "R7 row change in one bank");
        rd(1'b1, 2'd3, 12'd100, 8'd7, 16'h0F0F, "R6 earlier row kept");
        // back-to-back stream with refresh pressure (R9)
        for (int i = 0; i < 40; i++)
            rd(i[0], 2'd1, 12'd5, 8'd3, 16'hA534, "R9 data under refresh pressure");
        repeat (400) @(negedge clk);
        // self refresh (R10)
        selfref_req = 1'b1;
        t0 = 0;
        while (sd_cke && t0 < 60) begin @(negedge clk); t0++; end
        chk(!sd_cke, "R10 clock enable dropped", sd_cke, 0);
        repeat (40) begin
            @(negedge clk);
            chk(!sd_cke && !req_ready, "R10 held in self refresh", {sd_cke, req_ready}, 0);
        end
        selfref_req = 1'b0;
        while (!sd_cke) @(negedge clk);
        t0 = cyc;
        while (!req_ready) @(negedge clk);
        chk(cyc - t0 >= T_RFC, "R10 exit recovery", cyc - t0, T_RFC);
        rd(1'b0, 2'd1, 12'd5, 8'd3, 16'hA534, "R10 data kept through self refresh");
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        phase(1'b0);
        phase(1'b1);
        repeat (5) @(negedge clk);
        report();
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        report();
    end
endmodule